// File: doc/BRIEF.md
# Miss Entry Snoop Response Logic

This block decides how one outstanding cache miss entry reacts when a snoop arrives from the memory side. It compares the snoop's attributes with the entry's state and decides whether the snoop is ordered before or after the entry's own request. That ordering then selects the response. If the snoop comes first, the only possible action is to rewrite buffered upgrade requests. If the entry's request comes first, the snoop may be recorded for replay, the entry's pending copy may be marked for later invalidation or downgrade, and the snoop response may carry shared, memory-inhibit and supply-exclusive indications.

The entry keeps its in-service, downstream-pending, pending-dirty and primary-exclusive state elsewhere and presents it to this block as inputs. This block holds only the two post-fill flags: post-invalidate and post-downgrade. A one-cycle snoop strobe produces a combinational decision in the same cycle. The flag updates are registered on the following clock edge. The surrounding queue logic acts on the rewrite and append strobes. A service-start pulse clears both flags when the entry's request is issued.

Top module: `missSnoopUnit`

## Requirements
- R1: After reset both post flags read 0. While snpValid is 0, every decision output is 0.
- R2: A snoop precedes the entry when inService is 0, or when snpExpress and downstreamPend are both 1. In that case snpHandled is 0, rewritePrimary and rewriteDeferred both equal snpNeedsExcl, nothing is appended, no response signal is raised and no flag changes.
- R3: When the entry precedes the snoop, rewritePrimary is 0, rewriteDeferred equals snpNeedsExcl, and snpHandled is 1 unless the block stalls.
- R4: When the entry precedes the snoop and postInvalidate is already 1, snpHandled is 1 and the block takes no other action: no append, no response signal and no flag change.
- R5: When the entry precedes the snoop, postInvalidate is 0, and either pendingDirty or snpInvalidating is 1, appendValid is 1. In that case appendMarkPending equals downstreamPend AND primaryNeedsExcl.
- R6: In the R5 case with pendingDirty at 1, respMemInhibit and respSupplyExcl are both 1. Otherwise both are 0.
- R7: An append made by a snoop with snpNeedsExcl at 1 sets postInvalidate on the next edge.
- R8: When the entry precedes the snoop, postInvalidate is 0, snpNeedsExcl is 0 and snpUncacheable is 0, respShared is 1 and postDowngrade is set on the next edge.
- R9: When an append is required and primaryFull is 1, stall is 1 and every other decision output is 0 in that cycle. Neither flag changes.
- R10: A svcStart pulse clears both flags on the next edge. If a snoop sets a flag in the same cycle, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snpValid | input | 1 | One-cycle snoop strobe |
| snpNeedsExcl | input | 1 | Snoop needs an exclusive copy |
| snpInvalidating | input | 1 | Snoop invalidates other copies |
| snpExpress | input | 1 | Snoop bypasses downstream buffering |
| snpUncacheable | input | 1 | Snoop is uncacheable |
| inService | input | 1 | Entry's request has been issued |
| downstreamPend | input | 1 | Request is buffered at a lower level |
| pendingDirty | input | 1 | Entry awaits an owned copy |
| primaryNeedsExcl | input | 1 | Primary queue requires exclusivity |
| primaryFull | input | 1 | Primary target queue has no free slot |
| svcStart | input | 1 | Entry's request is being issued; clears flags |
| snpHandled | output | 1 | Entry takes part in the snoop response |
| rewritePrimary | output | 1 | Rewrite upgrades in the primary queue |
| rewriteDeferred | output | 1 | Rewrite upgrades in the deferred queue |
| appendValid | output | 1 | Append a snoop-sourced target to the primary queue |
| appendMarkPending | output | 1 | Mark-pending bit of the appended target |
| respShared | output | 1 | Assert shared on the snoop response |
| respMemInhibit | output | 1 | Inhibit memory from responding |
| respSupplyExcl | output | 1 | Response grants an exclusive copy |
| stall | output | 1 | Snoop must be retried; primary queue full |
| postInvalidate | output | 1 | Pending copy will be invalidated after the fill |
| postDowngrade | output | 1 | Pending copy will be downgraded after the fill |

## Verification
A table walks through the snoop patterns that separate the two ordering cases. It covers an entry not in service, an express snoop with downstream-pending set, and an express snoop without it. Each pattern is paired with an exclusive or a shared request so that the rewrite targets can be told apart. In the following case, the patterns separate the pending-dirty and invalidating append paths and the mark-pending combinations, and show uncacheable reads leaving the entry untouched. Directed sequences cover the cases that depend on earlier state: snoops after post-invalidate is already set, a stall with a flag already set, and a service-start pulse with and without a snoop in the same cycle.

// File: rtl/missSnoopPkg.sv
package missSnoopPkg;
  typedef struct packed {
    logic setPostInv;
    logic setPostDown;
  } flagStrobeT;
endpackage

// File: rtl/snoopDecide.sv
module snoopDecide
  import missSnoopPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic snpValid,
  input  logic snpNeedsExcl,
  input  logic snpInvalidating,
  input  logic snpExpress,
  input  logic snpUncacheable,
  input  logic inService,
  input  logic downstreamPend,
  input  logic pendingDirty,
  input  logic primaryNeedsExcl,
  input  logic primaryFull,
  input  logic postInvNow,
  output logic snpHandled,
  output logic rewritePrimary,
  output logic rewriteDeferred,
  output logic appendValid,
  output logic appendMarkPending,
  output logic respShared,
  output logic respMemInhibit,
  output logic respSupplyExcl,
  output logic stall,
  output flagStrobeT strobes
);
  logic snoopFirst;
  logic entryFirst;
  logic wantAppend;
  logic blocked;

  always_comb begin
    snoopFirst = snpValid && (!inService || (snpExpress && downstreamPend));
    entryFirst = snpValid && !snoopFirst;
    wantAppend = entryFirst && !postInvNow && (pendingDirty || snpInvalidating);
    blocked    = wantAppend && primaryFull;

    snpHandled        = 1'b0;
    rewritePrimary    = 1'b0;
    rewriteDeferred   = 1'b0;
    appendValid       = 1'b0;
    appendMarkPending = 1'b0;
    respShared        = 1'b0;
    respMemInhibit    = 1'b0;
    respSupplyExcl    = 1'b0;
    stall             = blocked;
    strobes           = '0;

    if (snoopFirst) begin
      rewritePrimary  = snpNeedsExcl;
      rewriteDeferred = snpNeedsExcl;
    end else if (entryFirst && !blocked) begin
      snpHandled      = 1'b1;
      rewriteDeferred = snpNeedsExcl;
      if (!postInvNow) begin
        appendValid       = wantAppend;
        appendMarkPending = wantAppend && downstreamPend && primaryNeedsExcl;
        respMemInhibit    = wantAppend && pendingDirty;
        respSupplyExcl    = wantAppend && pendingDirty;
        strobes.setPostInv = wantAppend && snpNeedsExcl;
        if (!snpNeedsExcl && !snpUncacheable) begin
          respShared          = 1'b1;
          strobes.setPostDown = 1'b1;
        end
      end
    end
  end

  a_r2_first_snoop_unhandled: assert property (@(posedge clk) disable iff (!rstN)
    rewritePrimary |-> (!snpHandled && !appendValid && !respShared));
  a_r6_inhibit_needs_append: assert property (@(posedge clk) disable iff (!rstN)
    respMemInhibit |-> (appendValid && snpHandled));
  a_r9_stall_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !(snpHandled || appendValid || respShared || rewriteDeferred));
endmodule

// File: rtl/snoopFlags.sv
module snoopFlags
  import missSnoopPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       svcStart,
  input  flagStrobeT strobes,
  output logic       postInvalidate,
  output logic       postDowngrade
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      postInvalidate <= 1'b0;
      postDowngrade  <= 1'b0;
    end else begin
      if (strobes.setPostInv)     postInvalidate <= 1'b1;
      else if (svcStart)          postInvalidate <= 1'b0;
      if (strobes.setPostDown)    postDowngrade  <= 1'b1;
      else if (svcStart)          postDowngrade  <= 1'b0;
    end
  end

  a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rstN)
    (svcStart && !strobes.setPostInv && !strobes.setPostDown) |=> (!postInvalidate && !postDowngrade));
endmodule

// File: rtl/missSnoopUnit.sv
module missSnoopUnit
  import missSnoopPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic snpValid,
  input  logic snpNeedsExcl,
  input  logic snpInvalidating,
  input  logic snpExpress,
  input  logic snpUncacheable,
  input  logic inService,
  input  logic downstreamPend,
  input  logic pendingDirty,
  input  logic primaryNeedsExcl,
  input  logic primaryFull,
  input  logic svcStart,
  output logic snpHandled,
  output logic rewritePrimary,
  output logic rewriteDeferred,
  output logic appendValid,
  output logic appendMarkPending,
  output logic respShared,
  output logic respMemInhibit,
  output logic respSupplyExcl,
  output logic stall,
  output logic postInvalidate,
  output logic postDowngrade
);
  flagStrobeT strobes;

  snoopDecide uDecide (
    .clk(clk), .rstN(rstN), .snpValid(snpValid), .snpNeedsExcl(snpNeedsExcl),
    .snpInvalidating(snpInvalidating), .snpExpress(snpExpress),
    .snpUncacheable(snpUncacheable), .inService(inService),
    .downstreamPend(downstreamPend), .pendingDirty(pendingDirty),
    .primaryNeedsExcl(primaryNeedsExcl), .primaryFull(primaryFull),
    .postInvNow(postInvalidate), .snpHandled(snpHandled),
    .rewritePrimary(rewritePrimary), .rewriteDeferred(rewriteDeferred),
    .appendValid(appendValid), .appendMarkPending(appendMarkPending),
    .respShared(respShared), .respMemInhibit(respMemInhibit),
    .respSupplyExcl(respSupplyExcl), .stall(stall), .strobes(strobes)
  );

  snoopFlags uFlags (
    .clk(clk), .rstN(rstN), .svcStart(svcStart), .strobes(strobes),
    .postInvalidate(postInvalidate), .postDowngrade(postDowngrade)
  );

  a_r9_stall_holds_flags: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !svcStart) |=> ($stable(postInvalidate) && $stable(postDowngrade)));
  a_r7_excl_append_sets_inv: assert property (@(posedge clk) disable iff (!rstN)
    (appendValid && snpNeedsExcl) |=> postInvalidate);
  a_r8_shared_sets_downgrade: assert property (@(posedge clk) disable iff (!rstN)
    respShared |=> postDowngrade);
endmodule

// File: tb/tb_missSnoopUnit.sv
module tb_missSnoopUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic snpValid = 0, snpNeedsExcl = 0, snpInvalidating = 0, snpExpress = 0;
  logic snpUncacheable = 0, inService = 0, downstreamPend = 0, pendingDirty = 0;
  logic primaryNeedsExcl = 0, primaryFull = 0, svcStart = 0;
  logic snpHandled, rewritePrimary, rewriteDeferred, appendValid, appendMarkPending;
  logic respShared, respMemInhibit, respSupplyExcl, stall, postInvalidate, postDowngrade;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  missSnoopUnit dut (.*);

  // in  = {needsExcl, invalidating, express, uncacheable, inService, downstreamPend, pendingDirty, primaryNeedsExcl, full}
  // out = {handled, rwPrimary, rwDeferred, append, markPending, shared, inhibit, supplyExcl, stall}
  // flg = {postInvalidate, postDowngrade} after the edge
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {9'b1_0_0_0_0_0_0_0_0, 9'b0_1_1_0_0_0_0_0_0, 2'b00}, // R2 not in service, exclusive
    {9'b0_0_0_0_0_0_0_0_0, 9'b0_0_0_0_0_0_0_0_0, 2'b00}, // R2 not in service, shared
    {9'b1_0_1_0_1_1_0_0_0, 9'b0_1_1_0_0_0_0_0_0, 2'b00}, // R2 express + downstream pending
    {9'b0_0_1_0_1_0_0_0_0, 9'b1_0_0_0_0_1_0_0_0, 2'b01}, // R3 R8 express alone follows
    {9'b1_0_0_0_1_1_1_1_0, 9'b1_0_1_1_1_0_1_1_0, 2'b10}, // R5 R6 R7 dirty, marked
    {9'b1_1_0_0_1_1_0_0_0, 9'b1_0_1_1_0_0_0_0_0, 2'b10}, // R5 R7 invalidating, not marked
    {9'b0_0_0_0_1_0_1_1_0, 9'b1_0_0_1_0_1_1_1_0, 2'b01}, // R5 R6 R8 dirty shared read
    {9'b0_0_0_1_1_0_0_0_0, 9'b1_0_0_0_0_0_0_0_0, 2'b00}, // R3 R8 uncacheable read
    {9'b1_0_0_0_1_0_1_0_1, 9'b0_0_0_0_0_0_0_0_1, 2'b00}, // R9 full, stall
    {9'b0_0_0_0_1_0_0_0_1, 9'b1_0_0_0_0_1_0_0_0, 2'b01}, // R9 full but no append
    {9'b1_0_0_0_0_0_1_0_1, 9'b0_1_1_0_0_0_0_0_0, 2'b00}  // R2 full ignored when first
  };

  function automatic logic [8:0] outs();
    return {snpHandled, rewritePrimary, rewriteDeferred, appendValid, appendMarkPending,
            respShared, respMemInhibit, respSupplyExcl, stall};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] v);
    {snpNeedsExcl, snpInvalidating, snpExpress, snpUncacheable, inService,
     downstreamPend, pendingDirty, primaryNeedsExcl, primaryFull} = v;
    snpValid = 1'b1;
  endtask

  // apply a snoop at negedge, check outputs, then flags after the edge
  task automatic snoop(input string req, input logic [8:0] v, input logic [8:0] eo, input logic [1:0] ef);
    @(negedge clk);
    drive(v);
    #1 check(req, outs(), eo);
    @(posedge clk);
    #1 check(req, {7'd0, postInvalidate, postDowngrade}, {7'd0, ef});
    snpValid = 1'b0;
  endtask

  task automatic startSvc();
    @(negedge clk);
    svcStart = 1'b1;
    @(posedge clk);
    #1 svcStart = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state and idle outputs
    check("R1", {7'd0, postInvalidate, postDowngrade}, 9'd0);
    check("R1", outs(), 9'd0);

    for (int i = 0; i < NV; i++) begin
      startSvc();
      snoop($sformatf("vector %0d", i), VEC[i][19:11], VEC[i][10:2], VEC[i][1:0]);
    end

    // R4: post-invalidate already set, exclusive dirty snoop does nothing more
    startSvc();
    snoop("R7 setup", 9'b1_1_0_0_1_0_0_0_0, 9'b1_0_1_1_0_0_0_0_0, 2'b10);
    snoop("R4 excl", 9'b1_0_0_0_1_1_1_1_0, 9'b1_0_1_0_0_0_0_0_0, 2'b10);
    snoop("R4 read", 9'b0_0_0_0_1_0_1_0_1, 9'b1_0_0_0_0_0_0_0_0, 2'b10);

    // R10: svcStart clears flags
    startSvc();
    check("R10 clear", {7'd0, postInvalidate, postDowngrade}, 9'd0);

    // R9: stall keeps an existing downgrade flag unchanged
    snoop("R8 setup", 9'b0_0_0_0_1_0_0_0_0, 9'b1_0_0_0_0_1_0_0_0, 2'b01);
    snoop("R9 hold", 9'b0_1_0_0_1_0_0_0_1, 9'b0_0_0_0_0_0_0_0_1, 2'b01);

    // R10: set wins over a simultaneous svcStart
    startSvc();
    @(negedge clk);
    svcStart = 1'b1;
    drive(9'b1_1_0_0_1_0_0_0_0);
    @(posedge clk);
    #1 check("R10 set wins", {7'd0, postInvalidate, postDowngrade}, 9'b10);
    snpValid = 1'b0;
    svcStart = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule